// File: doc/BRIEF.md
# Snooping Write-Through Coherent Data Cache

A small direct-mapped data cache controller that serves one processor and sits on a shared atomic bus. Each line holds one data word. Each line is in one of two states: a usable copy (valid) or no usable copy (invalid). Reads that find a valid line with a matching tag are answered locally. All other reads fetch the word over the bus and fill the line. Every write goes to memory over the bus. A write updates the cached copy only when that copy is already present; a write miss allocates nothing.

Other bus masters stay coherent with this cache through snooping. When another master writes over the bus to an address that this cache holds valid, the line is dropped. Reads by other masters leave the state alone. The processor must hold its request fields stable until the controller raises ready. The bus owner must never grant this cache in a cycle in which a foreign transaction is shown on the snoop port.

Address split: index = `cpu_addr_i[IDX_W-1:0]`, tag = the remaining upper bits.

Top module: `snoop_wt_cache`

## Requirements
- R1: After reset every line is invalid, ready and bus request are low while idle, and the first read of any address goes to the bus.
- R2: A read that misses raises `bus_req_o` with `bus_cmd_o`=0 (read) and the read address in the same cycle, and keeps `cpu_ready_o` low until the grant cycle. In the grant cycle it returns `bus_rdata_i` with ready high, and the line becomes valid with that tag and data.
- R3: A read that hits is answered in the cycle it is presented, with ready high, the cached word, and no bus request.
- R4: Every write raises `bus_req_o` with `bus_cmd_o`=1 (write), the address and the data. Ready rises only in the grant cycle.
- R5: A write that hits updates the cached word, and a later read of that address hits and returns the new data.
- R6: A write that misses allocates no line, so a later read of that address misses.
- R7: A snooped write (`snp_write_i`=1) to an address held valid makes that line invalid from the next cycle on.
- R8: A snooped read, or a snooped write to the same index with a different tag, leaves the line valid with its data.
- R9: A snoop is applied on the cycle it appears even while the processor is stalled waiting for grant. A write then finds no hit at grant and allocates nothing, and a read returns the data present at grant time.
- R10: While a request waits for grant, request, command, address and write data stay unchanged.
- R11: Two addresses sharing an index evict each other: filling the second makes the first miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor access request, held until ready |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | IDX_W+TAG_W | Word address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_ready_o | output | 1 | Access completes this cycle |
| cpu_rdata_o | output | DATA_W | Read data, valid with ready on a read |
| bus_req_o | output | 1 | Bus transaction request |
| bus_gnt_i | input | 1 | Grant; the transaction completes in this cycle |
| bus_cmd_o | output | 1 | 0 = bus read, 1 = bus write |
| bus_addr_o | output | IDX_W+TAG_W | Transaction address |
| bus_wdata_o | output | DATA_W | Data written to memory |
| bus_rdata_i | input | DATA_W | Memory data in the grant cycle of a read |
| snp_valid_i | input | 1 | Another master's transaction is on the bus |
| snp_write_i | input | 1 | The snooped transaction is a write |
| snp_addr_i | input | IDX_W+TAG_W | Address of the snooped transaction |

## Verification
The bench goes after four corner cases:
- A snooped write that arrives while a local write waits for grant. A design that checks the hit at issue time instead of at grant would revive a stale line.
- A write miss. A design that allocates on it would hit on a word it never fetched.
- A same-index snoop with a foreign tag. A design that compares only the index would drop a good line.
- Index conflicts between two tags. A design that mishandles them would return the wrong word on a hit.

Randomly varied grant latency checks that the request fields hold while waiting. The random snoops, partly aimed at the live address, show whether stale data can ever be returned on a hit.

// File: rtl/snoop_wt_pkg.sv
package snoop_wt_pkg;
  typedef enum logic {
    BUS_RD = 1'b0,
    BUS_WR = 1'b1
  } bus_cmd_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/line_store.sv
module line_store #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              fill_i,
  input  logic              upd_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              snp_valid_i,
  input  logic              snp_write_i,
  input  logic [IDX_W-1:0]  snp_idx_i,
  input  logic [TAG_W-1:0]  snp_tag_i
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];
  logic snp_match;

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];

  assign snp_match = snp_valid_i && snp_write_i && valid_q[snp_idx_i] &&
                     (tag_q[snp_idx_i] == snp_tag_i);

  // local fill wins; an atomic bus never overlaps it with a snoop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (fill_i && wr_idx_i == IDX_W'(i))
          valid_q[i] <= 1'b1;
        else if (snp_match && snp_idx_i == IDX_W'(i))
          valid_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < LINES; i++) begin
      if (fill_i && wr_idx_i == IDX_W'(i)) begin
        tag_q[i]  <= wr_tag_i;
        data_q[i] <= wr_data_i;
      end else if (upd_i && wr_idx_i == IDX_W'(i)) begin
        data_q[i] <= wr_data_i;
      end
    end
  end

  AST_SNOOP_DROPS_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_write_i && valid_q[snp_idx_i] && tag_q[snp_idx_i] == snp_tag_i &&
     !(fill_i && wr_idx_i == snp_idx_i)) |=> !valid_q[$past(snp_idx_i)]); // R7

  AST_SNOOP_READ_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && !snp_write_i && !fill_i) |=> valid_q == $past(valid_q)); // R8
endmodule

// File: rtl/bus_seq.sv
module bus_seq
  import snoop_wt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  bus_cmd_e          cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              gnt_i,
  output logic              req_o,
  output bus_cmd_e          cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              busy_o,
  output logic              done_o
);
  seq_state_e        state_q;
  bus_cmd_e          cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign busy_o = (state_q == SEQ_WAIT);
  assign req_o  = busy_o || start_i;
  assign cmd_o  = busy_o ? cmd_q  : cmd_i;
  assign addr_o = busy_o ? addr_q : addr_i;
  assign data_o = busy_o ? data_q : data_i;
  assign done_o = req_o && gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cmd_q   <= BUS_RD;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (start_i && !gnt_i) begin
          state_q <= SEQ_WAIT;
          cmd_q   <= cmd_i;
          addr_q  <= addr_i;
          data_q  <= data_i;
        end
        default: if (gnt_i) state_q <= SEQ_IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i) |=> (req_o && $stable(addr_o) && $stable(cmd_o) && $stable(data_o))); // R10
endmodule

// File: rtl/snoop_wt_cache.sv
module snoop_wt_cache
  import snoop_wt_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 16,
  localparam int ADDR_W = IDX_W + TAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              snp_valid_i,
  input  logic              snp_write_i,
  input  logic [ADDR_W-1:0] snp_addr_i
);
  logic [IDX_W-1:0]  cpu_idx;
  logic [TAG_W-1:0]  cpu_tag;
  logic              line_valid;
  logic [TAG_W-1:0]  line_tag;
  logic [DATA_W-1:0] line_data;
  logic              hit, busy, done, start, read_hit;
  bus_cmd_e          cmd_in, cmd_out;
  logic              fill, upd;

  assign cpu_idx = cpu_addr_i[IDX_W-1:0];
  assign cpu_tag = cpu_addr_i[ADDR_W-1:IDX_W];
  assign hit     = line_valid && (line_tag == cpu_tag);

  assign read_hit = cpu_req_i && !cpu_we_i && hit && !busy;
  assign start    = cpu_req_i && !busy && (cpu_we_i || !hit);
  assign cmd_in   = cpu_we_i ? BUS_WR : BUS_RD;

  bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .cmd_i  (cmd_in),
    .addr_i (cpu_addr_i),
    .data_i (cpu_wdata_i),
    .gnt_i  (bus_gnt_i),
    .req_o  (bus_req_o),
    .cmd_o  (cmd_out),
    .addr_o (bus_addr_o),
    .data_o (bus_wdata_o),
    .busy_o (busy),
    .done_o (done)
  );

  assign bus_cmd_o = cmd_out;

  // hit re-evaluated at grant so a snoop during the stall is honoured
  assign fill = done && (cmd_out == BUS_RD);
  assign upd  = done && (cmd_out == BUS_WR) && hit;

  line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (cpu_idx),
    .rd_valid_o (line_valid),
    .rd_tag_o   (line_tag),
    .rd_data_o  (line_data),
    .fill_i     (fill),
    .upd_i      (upd),
    .wr_idx_i   (bus_addr_o[IDX_W-1:0]),
    .wr_tag_i   (bus_addr_o[ADDR_W-1:IDX_W]),
    .wr_data_i  (fill ? bus_rdata_i : bus_wdata_o),
    .snp_valid_i(snp_valid_i),
    .snp_write_i(snp_write_i),
    .snp_idx_i  (snp_addr_i[IDX_W-1:0]),
    .snp_tag_i  (snp_addr_i[ADDR_W-1:IDX_W])
  );

  assign cpu_ready_o = read_hit || done;
  assign cpu_rdata_o = done ? bus_rdata_i : line_data;

  AST_HIT_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && !cpu_we_i && cpu_ready_o && !bus_gnt_i) |-> !bus_req_o); // R3

  AST_WRITE_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_we_i && cpu_ready_o) |->
      (bus_req_o && bus_gnt_i && bus_cmd_o == 1'b1 && bus_addr_o == cpu_addr_i &&
       bus_wdata_o == cpu_wdata_i)); // R4

  AST_MISS_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i) |-> !cpu_ready_o); // R2
endmodule

// File: tb/tb_snoop_wt_cache.sv
module tb_snoop_wt_cache;
  localparam int IDX_W = 3, TAG_W = 5, DATA_W = 16, ADDR_W = 8, LINES = 8;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic cpu_ready_o;
  logic [DATA_W-1:0] cpu_rdata_o;
  logic bus_req_o, bus_gnt = 0, bus_cmd_o;
  logic [ADDR_W-1:0] bus_addr_o;
  logic [DATA_W-1:0] bus_wdata_o, bus_rdata = '0;
  logic snp_valid = 0, snp_write = 0;
  logic [ADDR_W-1:0] snp_addr = '0;

  int n_chk = 0, n_err = 0;
  bit m_v [LINES];
  logic [TAG_W-1:0] m_t [LINES];
  logic [DATA_W-1:0] m_d [LINES];
  logic [DATA_W-1:0] mem [256];

  always #10 clk = ~clk;

  snoop_wt_cache #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ready_o(cpu_ready_o), .cpu_rdata_o(cpu_rdata_o),
    .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt), .bus_cmd_o(bus_cmd_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata),
    .snp_valid_i(snp_valid), .snp_write_i(snp_write), .snp_addr_i(snp_addr)
  );

  function automatic bit m_hit(logic [ADDR_W-1:0] a);
    return m_v[a[IDX_W-1:0]] && m_t[a[IDX_W-1:0]] == a[ADDR_W-1:IDX_W];
  endfunction

  task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", r, act, exp, $time);
    end
  endtask

  // model of a foreign transaction, applied at the clock edge it is seen on
  task automatic model_snoop(bit we, logic [ADDR_W-1:0] a);
    if (we) begin
      if (m_hit(a)) m_v[a[IDX_W-1:0]] = 0;
      mem[a] = DATA_W'($urandom);
    end
  endtask

  task automatic snoop(bit we, logic [ADDR_W-1:0] a);
    @(negedge clk);
    snp_valid = 1; snp_write = we; snp_addr = a;
    @(posedge clk);
    model_snoop(we, a);
    @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic access(bit we, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, int dly,
                        bit sn_en, bit sn_we, logic [ADDR_W-1:0] sa, string tg);
    bit eh;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d; bus_gnt = 0; snp_valid = 0;
    bus_rdata = DATA_W'($urandom);
    eh = !we && m_hit(a);
    #1;
    chk(bus_req_o == !eh, tg, 32'(bus_req_o), 32'(!eh));
    if (eh) begin
      chk(cpu_ready_o == 1'b1, "R3", 32'(cpu_ready_o), 1);
      chk(cpu_rdata_o == m_d[a[IDX_W-1:0]], tg, 32'(cpu_rdata_o), 32'(m_d[a[IDX_W-1:0]]));
      @(posedge clk);
    end else begin
      chk(cpu_ready_o == 1'b0, "R2", 32'(cpu_ready_o), 0);
      chk(bus_cmd_o == we, "R4", 32'(bus_cmd_o), 32'(we));
      chk(bus_addr_o == a, "R2", 32'(bus_addr_o), 32'(a));
      if (we) chk(bus_wdata_o == d, "R4", 32'(bus_wdata_o), 32'(d));
      for (int k = 0; k < dly; k++) begin
        if (k == 0 && sn_en) begin snp_valid = 1; snp_write = sn_we; snp_addr = sa; end
        @(posedge clk);
        if (k == 0 && sn_en) model_snoop(sn_we, sa);
        @(negedge clk);
        snp_valid = 0;
        #1;
        chk(bus_req_o && !cpu_ready_o && bus_addr_o == a && bus_cmd_o == we &&
            (!we || bus_wdata_o == d), "R10", {bus_req_o, cpu_ready_o, bus_addr_o}, {2'b10, a});
      end
      bus_gnt = 1;
      bus_rdata = we ? DATA_W'($urandom) : mem[a];
      #1;
      chk(cpu_ready_o == 1'b1, tg, 32'(cpu_ready_o), 1);
      if (!we) chk(cpu_rdata_o == mem[a], "R2", 32'(cpu_rdata_o), 32'(mem[a]));
      @(posedge clk);
      if (!we) begin
        m_v[a[IDX_W-1:0]] = 1; m_t[a[IDX_W-1:0]] = a[ADDR_W-1:IDX_W];
        m_d[a[IDX_W-1:0]] = mem[a];
      end else begin
        mem[a] = d;
        if (m_hit(a)) m_d[a[IDX_W-1:0]] = d;
      end
    end
    @(negedge clk);
    cpu_req = 0; bus_gnt = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0417));
    for (int i = 0; i < 256; i++) mem[i] = DATA_W'($urandom);
    for (int i = 0; i < LINES; i++) begin m_v[i] = 0; m_t[i] = '0; m_d[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(!cpu_ready_o && !bus_req_o, "R1", {cpu_ready_o, bus_req_o}, 0);

    access(0, 8'h13, 0, 1, 0, 0, 0, "R1");
    access(0, 8'h13, 0, 0, 0, 0, 0, "R3");
    access(1, 8'h13, 16'hbeef, 2, 0, 0, 0, "R5");
    access(0, 8'h13, 0, 0, 0, 0, 0, "R5");
    access(1, 8'h25, 16'h1234, 1, 0, 0, 0, "R6");
    access(0, 8'h25, 0, 0, 0, 0, 0, "R6");
    snoop(1, 8'h13);
    access(0, 8'h13, 0, 0, 0, 0, 0, "R7");
    snoop(0, 8'h13);
    access(0, 8'h13, 0, 0, 0, 0, 0, "R8");
    snoop(1, 8'h1b);
    access(0, 8'h13, 0, 0, 0, 0, 0, "R8");
    access(1, 8'h13, 16'h5a5a, 2, 1, 1, 8'h13, "R9");
    access(0, 8'h13, 0, 0, 0, 0, 0, "R9");
    access(0, 8'h40, 0, 2, 1, 1, 8'h40, "R9");
    access(0, 8'h0a, 0, 1, 0, 0, 0, "R11");
    access(0, 8'h12, 0, 1, 0, 0, 0, "R11");
    access(0, 8'h0a, 0, 0, 0, 0, 0, "R11");

    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] a, sa;
      a  = {3'b000, 2'($urandom % 4), 3'($urandom % 8)};
      sa = ($urandom % 2) ? a : {3'b000, 2'($urandom % 4), 3'($urandom % 8)};
      if ($urandom % 6 == 0) snoop(1'($urandom % 2), sa);
      access(1'($urandom % 3 == 0), a, DATA_W'($urandom), int'($urandom % 4),
             1'($urandom % 2), 1'($urandom % 2), sa, "R3");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule